// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between the register datapath and a 32-bit word-wide data memory port whose storage is addressed in bytes and ordered big-endian: the byte at a word's own address is the most significant byte of that word. It lets the datapath perform byte, halfword and word accesses through a port that only moves whole words with per-byte write enables.

For a store, the block takes a byte address, an access size and register data. It produces the word address, four byte-lane write enables and write data with the byte or halfword copied into every lane. For a load, it issues the same word address and then selects the addressed byte or halfword from the returned word. It sign-extends that value to 32 bits, or zero-extends it when the request is marked unsigned. Accesses that break their size's alignment rule are flagged and never split into two memory operations.

The request is registered. Address, enables, write data and the misalignment flag appear one cycle after the request. The memory port is expected to return read data combinationally for the presented word address, and the extracted load result is valid in that same cycle.

Top module: `lane_aligner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the word address, byte enables, write data, misalignment flag and load result are all zero.
- R2: One cycle after a valid request, the word address output equals request address bits [31:2]. In cycles that follow no valid request, the word address holds its last value.
- R3: Byte enable bit 3 controls data bits [31:24] and bit 0 controls bits [7:0]. A byte store to byte offset k (address bits [1:0]) asserts only enable bit 3-k, one cycle after the request.
- R4: Size encoding is 00 byte, 01 halfword, 10 word and 11 word. A halfword store at offset 0 asserts enables 1100, at offset 2 it asserts 0011, and an aligned word store asserts 1111.
- R5: On a store, the write data output carries the low byte of the register data copied into all four lanes for a byte store, the low halfword copied into both halves for a halfword store, and the register data unchanged for a word store.
- R6: A halfword request with address bit 0 set, or a word request with address bits [1:0] nonzero, raises the misalignment flag for one cycle. In that cycle all byte enables are 0 and the load result is 0. A byte request is never misaligned.
- R7: For an aligned load with the unsigned input low, the load result is the addressed byte or halfword taken from the returned word (offset 0 from the most significant end) and sign-extended to 32 bits. A word load returns the word unchanged.
- R8: For a byte or halfword load with the unsigned input high, the result is zero-extended instead.
- R9: A cycle that follows no valid request, or a load request, drives all byte enables to 0. The load result is 0 in every cycle that does not follow an aligned load request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Zero-extend narrow loads instead of sign-extending |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Register data to store |
| mem_rdata | input | 32 | Word returned by memory for the presented word address |
| word_addr | output | 30 | Word address to memory |
| byte_en | output | 4 | Per-lane write enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Lane-positioned store data |
| misalign | output | 1 | The previous request broke its alignment rule |
| load_data | output | 32 | Extracted and extended load result |

## Verification
A corrupted offset or size in the request register would show on the byte enables, or in the lane chosen for a load, in the very next cycle. Every store is written into a bench-side memory through the enables. A wrong lane or replication therefore also shows on any later load that reads the same word back. A stale or wrongly cleared load-active bit shows as a nonzero or missing load result one cycle after the request. The random phase mixes every size, offset, direction and extension mode, so a wrong misalignment decision appears on both the flag and the enables within a cycle.

// File: rtl/lane_pkg.sv
package lane_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;
endpackage

// File: rtl/lane_align_check.sv
module lane_align_check
    import lane_pkg::*;
(
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic             bad
);
    always_comb begin
        unique case (size)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = off[0];
            default: bad = (off != '0);
        endcase
    end
endmodule

// File: rtl/lane_store_gen.sv
module lane_store_gen
    import lane_pkg::*;
(
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] lane_data
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(i);
        logic sel;
        always_comb begin
            unique case (size)
                SZ_BYTE: sel = (off == LANE_OFF);
                SZ_HALF: sel = (off[OFF_W-1] == LANE_OFF[OFF_W-1]);
                default: sel = 1'b1;
            endcase
        end
        assign be[LANES-1-i] = sel;
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: lane_data = {LANES{wdata[7:0]}};
            SZ_HALF: lane_data = {(LANES/2){wdata[15:0]}};
            default: lane_data = wdata;
        endcase
    end
endmodule

// File: rtl/lane_load_ext.sv
module lane_load_ext
    import lane_pkg::*;
(
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic              uns,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [7:0]  lane_b [LANES];
    logic [7:0]  pick_b;
    logic [15:0] pick_h;

    for (genvar i = 0; i < LANES; i++) begin : g_split
        assign lane_b[i] = rdata[DATA_W-1-8*i -: 8];
    end

    always_comb begin
        pick_b = lane_b[off];
        pick_h = off[OFF_W-1] ? rdata[15:0] : rdata[31:16];
        unique case (size)
            SZ_BYTE: result = uns ? {{(DATA_W-8){1'b0}}, pick_b}
                                  : {{(DATA_W-8){pick_b[7]}}, pick_b};
            SZ_HALF: result = uns ? {{(DATA_W-16){1'b0}}, pick_h}
                                  : {{(DATA_W-16){pick_h[15]}}, pick_h};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
    import lane_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic                req_unsigned,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [ADDR_W-OFF_W-1:0] word_addr,
    output logic [LANES-1:0]    byte_en,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                misalign,
    output logic [DATA_W-1:0]   load_data
);
    localparam int WA_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic [WA_W-1:0]   waddr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        logic              mis;
        logic              ld_act;
        acc_size_e         ld_size;
        logic [OFF_W-1:0]  ld_off;
        logic              ld_uns;
    } state_t;

    state_t st_d, st_q;

    acc_size_e         sz_in;
    logic [OFF_W-1:0]  off_in;
    logic              bad;
    logic [LANES-1:0]  be_raw;
    logic [DATA_W-1:0] lane_data;
    logic [DATA_W-1:0] ext_data;

    assign sz_in  = acc_size_e'(req_size);
    assign off_in = req_addr[OFF_W-1:0];

    lane_align_check i_check (
        .size (sz_in),
        .off  (off_in),
        .bad  (bad)
    );

    lane_store_gen i_store (
        .size      (sz_in),
        .off       (off_in),
        .wdata     (req_wdata),
        .be        (be_raw),
        .lane_data (lane_data)
    );

    lane_load_ext i_load (
        .size   (st_q.ld_size),
        .off    (st_q.ld_off),
        .uns    (st_q.ld_uns),
        .rdata  (mem_rdata),
        .result (ext_data)
    );

    always_comb begin
        st_d        = st_q;
        st_d.be     = '0;
        st_d.mis    = 1'b0;
        st_d.ld_act = 1'b0;
        if (req_valid) begin
            st_d.waddr   = req_addr[ADDR_W-1:OFF_W];
            st_d.wdata   = lane_data;
            st_d.mis     = bad;
            st_d.be      = (req_write && !bad) ? be_raw : '0;
            st_d.ld_act  = !req_write && !bad;
            st_d.ld_size = sz_in;
            st_d.ld_off  = off_in;
            st_d.ld_uns  = req_unsigned;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_addr = st_q.waddr;
    assign byte_en   = st_q.be;
    assign mem_wdata = st_q.wdata;
    assign misalign  = st_q.mis;
    assign load_data = st_q.ld_act ? ext_data : '0;
endmodule

// File: rtl/lane_aligner_chk.sv
module lane_aligner_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic [ADDR_W-3:0] word_addr,
    input logic [3:0]        byte_en,
    input logic              misalign,
    input logic [31:0]       load_data
);
    // R6
    misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (byte_en == 4'b0000 && load_data == 32'd0));

    // R3
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(byte_en) != 3) && (byte_en != 4'b0110) && (byte_en != 4'b1010)
        && (byte_en != 4'b0101) && (byte_en != 4'b1001));

    // R2
    waddr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (word_addr == $past(req_addr[ADDR_W-1:2])));

    // R2
    waddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(word_addr));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (byte_en == 4'b0000 && load_data == 32'd0 && !misalign));

    // R9
    read_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (byte_en == 4'b0000));

    // R6
    byte_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b00) |=> !misalign);
endmodule

bind lane_aligner lane_aligner_chk #(.ADDR_W(ADDR_W)) i_lane_aligner_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .word_addr (word_addr),
    .byte_en   (byte_en),
    .misalign  (misalign),
    .load_data (load_data)
);

// File: tb/test_lane_aligner.sv
`timescale 1ns/1ps
module test_lane_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] mem_rdata;
    logic [29:0] word_addr;
    logic [3:0]  byte_en;
    logic [31:0] mem_wdata;
    logic        misalign;
    logic [31:0] load_data;

    int errors = 0;
    int checks = 0;

    logic [7:0]  ref_b [0:63];
    logic [31:0] dmem  [0:15];

    logic [29:0] exp_wa;
    logic [3:0]  exp_en;
    logic [31:0] exp_wd;
    logic        exp_mis;
    logic [31:0] exp_ld;
    logic [5:0]  exp_idx;

    always #10 clk = ~clk;

    lane_aligner i_lane_aligner (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_size     (req_size),
        .req_unsigned (req_unsigned),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .mem_rdata    (mem_rdata),
        .word_addr    (word_addr),
        .byte_en      (byte_en),
        .mem_wdata    (mem_wdata),
        .misalign     (misalign),
        .load_data    (load_data)
    );

    assign mem_rdata = dmem[word_addr[3:0]];

    always @(posedge clk) begin
        logic [31:0] w;
        w = dmem[word_addr[3:0]];
        for (int k = 0; k < 4; k++) begin
            if (byte_en[3-k]) w[31-8*k -: 8] = mem_wdata[31-8*k -: 8];
        end
        dmem[word_addr[3:0]] <= w;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic v, input logic w, input logic [1:0] sz,
                        input logic u, input logic [31:0] a, input logic [31:0] d);
        logic [1:0] off;
        logic [7:0] b;
        logic [15:0] h;
        logic [5:0] base;
        string tag_en;
        string tag_ld;
        @(negedge clk);
        req_valid = v; req_write = w; req_size = sz;
        req_unsigned = u; req_addr = a; req_wdata = d;
        off  = a[1:0];
        base = {a[5:2], 2'b00};
        exp_mis = v && ((sz == 2'b01 && a[0]) || (sz[1] && off != 2'b00));
        exp_en  = 4'b0000;
        exp_ld  = 32'd0;
        tag_en  = v ? ((sz == 2'b00) ? "R3" : "R4") : "R9";
        tag_ld  = (v && !w) ? (u ? "R8" : "R7") : "R9";
        if (v) begin
            exp_wa  = a[31:2];
            exp_idx = a[5:0];
            if (sz == 2'b00) exp_wd = {4{d[7:0]}};
            else if (sz == 2'b01) exp_wd = {2{d[15:0]}};
            else exp_wd = d;
        end
        if (v && w && !exp_mis) begin
            if (sz == 2'b00) exp_en = 4'b1000 >> off;
            else if (sz == 2'b01) exp_en = off[1] ? 4'b0011 : 4'b1100;
            else exp_en = 4'b1111;
        end
        if (v && !w && !exp_mis) begin
            if (sz == 2'b00) begin
                b = ref_b[a[5:0]];
                exp_ld = u ? {24'd0, b} : {{24{b[7]}}, b};
            end else if (sz == 2'b01) begin
                h = {ref_b[a[5:0]], ref_b[a[5:0] + 6'd1]};
                exp_ld = u ? {16'd0, h} : {{16{h[15]}}, h};
            end else begin
                exp_ld = {ref_b[base], ref_b[base+6'd1], ref_b[base+6'd2], ref_b[base+6'd3]};
            end
        end
        @(posedge clk);
        #1;
        chk("R2", {2'b00, word_addr}, {2'b00, exp_wa});
        chk(exp_mis ? "R6" : tag_en, {28'd0, byte_en}, {28'd0, exp_en});
        chk(v ? "R6" : "R9", {31'd0, misalign}, {31'd0, exp_mis});
        chk(exp_mis ? "R6" : tag_ld, load_data, exp_ld);
        if (exp_en != 4'b0000) begin
            chk("R5", mem_wdata, exp_wd);
            for (int k = 0; k < 4; k++) begin
                if (exp_en[3-k]) ref_b[{exp_idx[5:2], 2'(k)}] = exp_wd[31-8*k -: 8];
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_b[i] = 8'((i * 37 + 5) & 8'hFF);
        for (int wd = 0; wd < 16; wd++)
            dmem[wd] = {ref_b[4*wd], ref_b[4*wd+1], ref_b[4*wd+2], ref_b[4*wd+3]};
        exp_wa = '0; exp_wd = '0; exp_idx = '0;

        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", {2'b00, word_addr}, 32'd0);
        chk("R1", {28'd0, byte_en}, 32'd0);
        chk("R1", mem_wdata, 32'd0);
        chk("R1", {31'd0, misalign}, 32'd0);
        chk("R1", load_data, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", {28'd0, byte_en}, 32'd0);
        chk("R1", load_data, 32'd0);

        // R3: byte stores at each offset
        for (int o = 0; o < 4; o++)
            step(1, 1, 2'b00, 0, 32'h0000_0010 + 32'(o), 32'hA5A5_A500 + 32'(o * 17));
        // R4: halfword and word stores
        step(1, 1, 2'b01, 0, 32'h0000_0020, 32'h1234_8765);
        step(1, 1, 2'b01, 0, 32'h0000_0022, 32'h0000_F00D);
        step(1, 1, 2'b10, 0, 32'h0000_0024, 32'hDEAD_BEEF);
        step(1, 1, 2'b11, 0, 32'h0000_0028, 32'h0BAD_CAFE);
        // R7 / R8: loads back with sign and zero extension
        for (int o = 0; o < 4; o++) begin
            step(1, 0, 2'b00, 0, 32'h0000_0010 + 32'(o), 32'd0);
            step(1, 0, 2'b00, 1, 32'h0000_0010 + 32'(o), 32'd0);
        end
        step(1, 0, 2'b01, 0, 32'h0000_0020, 32'd0);
        step(1, 0, 2'b01, 1, 32'h0000_0020, 32'd0);
        step(1, 0, 2'b01, 0, 32'h0000_0022, 32'd0);
        step(1, 0, 2'b10, 0, 32'h0000_0024, 32'd0);
        // R6: misaligned halfword and word, load and store
        step(1, 1, 2'b01, 0, 32'h0000_0031, 32'hFFFF_FFFF);
        step(1, 1, 2'b10, 0, 32'h0000_0032, 32'hFFFF_FFFF);
        step(1, 0, 2'b10, 0, 32'h0000_0033, 32'd0);
        step(1, 0, 2'b01, 1, 32'h0000_0003, 32'd0);
        // R9: idle cycles hold address and clear enables
        step(0, 1, 2'b10, 0, 32'h0000_0000, 32'h1111_1111);
        step(0, 0, 2'b00, 0, 32'h0000_0004, 32'd0);
        // Mixed random traffic
        for (int n = 0; n < 600; n++) begin
            logic [31:0] ra;
            ra = $urandom;
            step(($urandom % 5) != 0, $urandom % 2, 2'($urandom % 4),
                 $urandom % 2, ra, $urandom);
        end
        step(0, 0, 2'b00, 0, 32'd0, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule